// File: doc/BRIEF.md
# Coarse and Epoch Timestamp Writer

This block holds the coarse time base of a time-to-digital converter and turns hit events into tagged records in a circular buffer. A coarse counter advances on every system clock. An epoch counter advances once each time the coarse counter wraps. At a 5 ns clock the coarse counter spans about 10 µs, and the pair covers roughly 45 minutes. For each hit the block stores one word with the coarse count of the hit's cycle and the fine code from the interpolator. An epoch word is stored only when the coarse counter has wrapped since the last hit, so that idle epochs cost no buffer space.

A two-state machine tracks whether an epoch word is owed. In `ST_EPOCH_DUE` the next hit writes the current epoch word and its hit word in the same cycle, epoch first. In `ST_SYNCED` a hit writes only its hit word. The transitions are:
- **wrap**: any state to `ST_EPOCH_DUE` in a cycle where the coarse counter wraps.
- **sync**: `ST_EPOCH_DUE` to `ST_SYNCED` on a hit with no wrap.
- **hold**: otherwise the state stays.

Reset enters `ST_EPOCH_DUE`, so the first hit is anchored to epoch 0. The buffer has a power-of-two depth. When it is full it drops its oldest entries to make room and raises a sticky overrun flag. The consumer pops the head word with a read enable.

Top module: `tstamp_ring_writer`

## Requirements
- R1: While `rst_n` is low, the coarse and epoch counters are 0, the buffer is empty (`rd_level` 0, `rd_empty` 1, `rd_full` 0, `rd_data` 0) and `overrun` is 0.
- R2: The coarse counter is 11 bits wide and steps by one on every clock, wrapping from 2047 to 0. A hit word has tag bit 28 = 0, the fine code in bits 9:0 and the coarse value of the hit's cycle in bits 20:10. The remaining bits are zero.
- R3: The epoch counter is 28 bits wide and steps by one only on the clock where the coarse counter wraps. An epoch word has tag bit 28 = 1 and the epoch value in bits 27:0.
- R4: No word is written in a cycle without a hit. A hit in `ST_SYNCED` writes exactly one word, its hit word.
- R5: After reset the machine is in `ST_EPOCH_DUE`, so the first hit is preceded by an epoch word carrying 0.
- R6: A hit in the coarse wrap cycle uses the pre-wrap epoch and carries coarse 2047. The machine is in `ST_EPOCH_DUE` afterwards, so the next hit gets an epoch word with the new epoch.
- R7: The buffer is first in, first out. `rd_data` shows the oldest word, and `rd_en` removes it when the buffer is not empty. `rd_en` on an empty buffer has no effect. `rd_level` counts the stored words, and `rd_full` is high exactly when the level equals the depth.
- R8: Writes that exceed the depth discard the oldest words, and the level stays at the depth. `overrun` then rises and stays high until reset.
- R9: A hit in `ST_EPOCH_DUE` writes two words in one cycle, the epoch word ahead of the hit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A hit occurred in this cycle |
| hit_fine | input | FINE_W | Fine interpolator code of the hit |
| rd_en | input | 1 | Pop the head word |
| rd_data | output | WORD_W | Head word, zero when empty |
| rd_empty | output | 1 | Buffer holds no word |
| rd_full | output | 1 | Buffer holds DEPTH words |
| rd_level | output | LVL_W | Number of stored words |
| overrun | output | 1 | Sticky flag: a stored word was discarded |

## Verification
The test drives hits well away from a wrap to show that a synced hit writes a single word. It drives the first hit after reset to show the initial epoch anchor. It drives a hit exactly in the wrap cycle, both with no epoch word owed and with one owed, to separate pre-wrap and post-wrap epoch assignment. It also lets the counter wrap with no hits, to show that idle epochs write nothing. Bursts without reads, reads combined with hits, and a two-word write into an almost-full buffer separate plain filling from overwrite. A pop on an empty buffer is also tried.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

    // Whether an epoch word is owed ahead of the next hit word
    typedef enum logic {
        ST_SYNCED    = 1'b0,
        ST_EPOCH_DUE = 1'b1
    } tsw_state_e;

    localparam logic TAG_HIT   = 1'b0;
    localparam logic TAG_EPOCH = 1'b1;

endpackage

// File: rtl/tsw_timebase.sv
module tsw_timebase #(
    parameter int COARSE_W = 11,
    parameter int EPOCH_W  = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [COARSE_W-1:0] coarse,
    output logic [EPOCH_W-1:0]  epoch,
    output logic                wrap
);

    logic [COARSE_W-1:0] coarse_q;
    logic [EPOCH_W-1:0]  epoch_q;

    // The coarse value is at its top code, so it wraps at this edge
    assign wrap = &coarse_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
            epoch_q  <= '0;
        end else begin
            coarse_q <= coarse_q + 1'b1;
            if (wrap) begin
                epoch_q <= epoch_q + 1'b1;
            end
        end
    end

    assign coarse = coarse_q;
    assign epoch  = epoch_q;

endmodule

// File: rtl/tsw_record_fsm.sv
module tsw_record_fsm
    import tsw_pkg::*;
#(
    parameter int COARSE_W = 11,
    parameter int EPOCH_W  = 28,
    parameter int FINE_W   = 10,
    parameter int WORD_W   = 29
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit_valid,
    input  logic [FINE_W-1:0]   hit_fine,
    input  logic [COARSE_W-1:0] coarse,
    input  logic [EPOCH_W-1:0]  epoch,
    input  logic                wrap,
    output logic [1:0]          wr_cnt,
    output logic [WORD_W-1:0]   wr_word0,
    output logic [WORD_W-1:0]   wr_word1
);

    tsw_state_e state_q;
    tsw_state_e state_d;
    logic [WORD_W-1:0] hit_word;
    logic [WORD_W-1:0] epoch_word;

    // Record formatting
    always_comb begin
        hit_word                      = '0;
        hit_word[WORD_W-1]            = TAG_HIT;
        hit_word[FINE_W-1:0]          = hit_fine;
        hit_word[FINE_W +: COARSE_W]  = coarse;
        epoch_word                    = '0;
        epoch_word[WORD_W-1]          = TAG_EPOCH;
        epoch_word[EPOCH_W-1:0]       = epoch;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EPOCH_DUE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and write lanes
    always_comb begin
        state_d  = state_q;
        wr_cnt   = 2'd0;
        wr_word0 = hit_word;
        wr_word1 = hit_word;
        unique case (state_q)
            ST_SYNCED: begin
                if (hit_valid) begin
                    wr_cnt = 2'd1;
                end
                if (wrap) begin
                    state_d = ST_EPOCH_DUE;
                end
            end
            ST_EPOCH_DUE: begin
                if (hit_valid) begin
                    wr_cnt   = 2'd2;
                    wr_word0 = epoch_word;
                    wr_word1 = hit_word;
                    if (!wrap) begin
                        state_d = ST_SYNCED;
                    end
                end
            end
            default: begin
                state_d = ST_EPOCH_DUE;
            end
        endcase
    end

endmodule

// File: rtl/tsw_ring.sv
module tsw_ring #(
    parameter int WORD_W = 29,
    parameter int DEPTH  = 16,
    parameter int LVL_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wr_cnt,
    input  logic [WORD_W-1:0] wr_word0,
    input  logic [WORD_W-1:0] wr_word1,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic [LVL_W-1:0]  level,
    output logic              overrun
);

    localparam int AW = $clog2(DEPTH);
    localparam int SW = LVL_W + 1;
    localparam logic [SW-1:0] DEPTH_S = SW'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr_q;
    logic [AW-1:0]     rd_ptr_q;
    logic [LVL_W-1:0]  level_q;
    logic              overrun_q;

    logic              pop;
    logic [SW-1:0]     sum;
    logic [SW-1:0]     drop;

    always_comb begin
        pop  = rd_en && (level_q != '0);
        sum  = {1'b0, level_q} - SW'(pop) + SW'(wr_cnt);
        drop = (sum > DEPTH_S) ? (sum - DEPTH_S) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q  <= '0;
            rd_ptr_q  <= '0;
            level_q   <= '0;
            overrun_q <= 1'b0;
        end else begin
            wr_ptr_q <= wr_ptr_q + AW'(wr_cnt);
            rd_ptr_q <= rd_ptr_q + AW'(pop) + AW'(drop);
            level_q  <= LVL_W'(sum - drop);
            if (drop != '0) begin
                overrun_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_cnt != 2'd0) begin
            mem[wr_ptr_q] <= wr_word0;
        end
        if (wr_cnt == 2'd2) begin
            mem[wr_ptr_q + AW'(1)] <= wr_word1;
        end
    end

    assign empty   = (level_q == '0);
    assign full    = (level_q == LVL_W'(DEPTH));
    assign level   = level_q;
    assign overrun = overrun_q;
    assign rd_data = empty ? '0 : mem[rd_ptr_q];

endmodule

// File: rtl/tstamp_ring_writer.sv
module tstamp_ring_writer #(
    parameter int COARSE_W = 11,
    parameter int EPOCH_W  = 28,
    parameter int FINE_W   = 10,
    parameter int DEPTH    = 16,
    localparam int PAY_W   = (EPOCH_W > COARSE_W + FINE_W) ? EPOCH_W : (COARSE_W + FINE_W),
    localparam int WORD_W  = PAY_W + 1,
    localparam int LVL_W   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    input  logic [FINE_W-1:0] hit_fine,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_full,
    output logic [LVL_W-1:0]  rd_level,
    output logic              overrun
);

    logic [COARSE_W-1:0] coarse;
    logic [EPOCH_W-1:0]  epoch;
    logic                wrap;
    logic [1:0]          wr_cnt;
    logic [WORD_W-1:0]   wr_word0;
    logic [WORD_W-1:0]   wr_word1;

    tsw_timebase #(
        .COARSE_W (COARSE_W),
        .EPOCH_W  (EPOCH_W)
    ) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .coarse (coarse),
        .epoch  (epoch),
        .wrap   (wrap)
    );

    tsw_record_fsm #(
        .COARSE_W (COARSE_W),
        .EPOCH_W  (EPOCH_W),
        .FINE_W   (FINE_W),
        .WORD_W   (WORD_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_valid (hit_valid),
        .hit_fine  (hit_fine),
        .coarse    (coarse),
        .epoch     (epoch),
        .wrap      (wrap),
        .wr_cnt    (wr_cnt),
        .wr_word0  (wr_word0),
        .wr_word1  (wr_word1)
    );

    tsw_ring #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .LVL_W  (LVL_W)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cnt   (wr_cnt),
        .wr_word0 (wr_word0),
        .wr_word1 (wr_word1),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .empty    (rd_empty),
        .full     (rd_full),
        .level    (rd_level),
        .overrun  (overrun)
    );

endmodule

// File: rtl/tsw_checker.sv
module tsw_checker #(
    parameter int COARSE_W = 11,
    parameter int EPOCH_W  = 28,
    parameter int DEPTH    = 16,
    parameter int LVL_W    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hit_valid,
    input logic                rd_en,
    input logic                rd_empty,
    input logic [LVL_W-1:0]    rd_level,
    input logic                overrun,
    input logic [COARSE_W-1:0] coarse,
    input logic [EPOCH_W-1:0]  epoch
);

    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

    AST_COARSE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> coarse == $past(coarse) + 1'b1); // R2

    AST_EPOCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(&coarse) |=> $stable(epoch)); // R3

    AST_EPOCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (&coarse) |=> epoch == $past(epoch) + 1'b1); // R3

    AST_NO_HIT_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |=> rd_level <= $past(rd_level)); // R4

    AST_HIT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !rd_en && rd_level < DEPTH_L) |=> rd_level > $past(rd_level)); // R2

    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_empty && !hit_valid) |=> rd_empty); // R7

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_level <= DEPTH_L); // R8

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R8

endmodule

bind tstamp_ring_writer tsw_checker #(
    .COARSE_W (COARSE_W),
    .EPOCH_W  (EPOCH_W),
    .DEPTH    (DEPTH),
    .LVL_W    (LVL_W)
) u_tsw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_valid (hit_valid),
    .rd_en     (rd_en),
    .rd_empty  (rd_empty),
    .rd_level  (rd_level),
    .overrun   (overrun),
    .coarse    (coarse),
    .epoch     (epoch)
);

// File: tb/tstamp_ring_writer_test.sv
module tstamp_ring_writer_test;

    localparam int CW = 11;
    localparam int EW = 28;
    localparam int FW = 10;
    localparam int D  = 16;
    localparam int W  = 29;
    localparam int LW = 5;
    localparam int CMAX = 2047;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          hit_valid;
    logic [FW-1:0] hit_fine;
    logic          rd_en;
    logic [W-1:0]  rd_data;
    logic          rd_empty;
    logic          rd_full;
    logic [LW-1:0] rd_level;
    logic          overrun;

    tstamp_ring_writer #(
        .COARSE_W (CW), .EPOCH_W (EW), .FINE_W (FW), .DEPTH (D)
    ) uut (
        .clk (clk), .rst_n (rst_n), .hit_valid (hit_valid), .hit_fine (hit_fine),
        .rd_en (rd_en), .rd_data (rd_data), .rd_empty (rd_empty), .rd_full (rd_full),
        .rd_level (rd_level), .overrun (overrun)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit cmp_on = 0;

    // Reference model state
    int           m_coarse;
    int           m_epoch;
    bit           m_pend;
    bit           m_ovr;
    logic [W-1:0] m_q [$];

    task automatic chk(string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_coarse = 0; m_epoch = 0; m_pend = 1; m_ovr = 0;
            m_q.delete();
        end else begin
            if (rd_en && m_q.size() > 0) void'(m_q.pop_front());
            if (hit_valid) begin
                if (m_pend) m_q.push_back({1'b1, EW'(m_epoch)});
                m_q.push_back({1'b0, 7'd0, CW'(m_coarse), hit_fine});
            end
            while (m_q.size() > D) begin
                void'(m_q.pop_front());
                m_ovr = 1;
            end
            if (m_coarse == CMAX) begin
                m_pend = 1;
                m_epoch++;
            end else if (hit_valid) begin
                m_pend = 0;
            end
            m_coarse = (m_coarse + 1) % (CMAX + 1);
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R7 level", rd_level, m_q.size());
            chk("R7 empty", rd_empty, m_q.size() == 0);
            chk("R7 full", rd_full, m_q.size() == D);
            chk("R8 overrun", overrun, m_ovr);
            chk("R2 head word", rd_data, (m_q.size() > 0) ? m_q[0] : '0);
        end
    end

    task automatic drive(bit hv, logic [FW-1:0] f, bit rd);
        hit_valid = hv; hit_fine = f; rd_en = rd;
        @(negedge clk);
        hit_valid = 0; rd_en = 0;
    endtask

    task automatic wait_top();
        while (m_coarse != CMAX) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog: actual expired expected finished");
        summary();
    end

    initial begin
        int exp_c;
        rst_n = 0; hit_valid = 0; hit_fine = '0; rd_en = 0;
        repeat (4) @(negedge clk);
        chk("R1 level", rd_level, 0);
        chk("R1 empty", rd_empty, 1);
        chk("R1 full", rd_full, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 data", rd_data, 0);
        rst_n = 1;
        cmp_on = 1;

        // First hit after reset
        repeat (5) @(negedge clk);
        exp_c = m_coarse;
        drive(1, 10'h155, 0);
        chk("R5 first word tag", rd_data[W-1], 1);
        chk("R5 epoch value", rd_data[EW-1:0], 0);
        chk("R9 two words", rd_level, 2);
        drive(0, '0, 1);
        chk("R9 hit follows epoch", rd_data[W-1], 0);
        chk("R2 coarse field", rd_data[FW +: CW], exp_c);
        chk("R2 fine field", rd_data[FW-1:0], 10'h155);
        drive(0, '0, 1);

        // Synced hit
        drive(1, 10'h02a, 0);
        chk("R4 single word", rd_level, 1);
        chk("R4 hit tag", rd_data[W-1], 0);
        drive(0, '0, 1);

        // Hit in the wrap cycle with nothing owed
        wait_top();
        drive(1, 10'h3ff, 0);
        chk("R6 single word at wrap", rd_level, 1);
        chk("R6 coarse at wrap", rd_data[FW +: CW], CMAX);
        drive(0, '0, 1);
        repeat (3) @(negedge clk);
        drive(1, 10'h001, 0);
        chk("R3 epoch tag", rd_data[W-1], 1);
        chk("R6 new epoch", rd_data[EW-1:0], 1);
        drive(0, '0, 1);
        drive(0, '0, 1);

        // Idle across a wrap
        wait_top();
        repeat (10) @(negedge clk);
        chk("R4 idle across wrap", rd_level, 0);
        drive(1, 10'h0f0, 0);
        chk("R3 epoch advanced", rd_data[EW-1:0], 2);
        drive(0, '0, 1);
        drive(0, '0, 1);

        // Hit in the wrap cycle while an epoch word is owed
        wait_top();
        @(negedge clk);
        wait_top();
        drive(1, 10'h0aa, 0);
        chk("R6 pre-wrap epoch", rd_data[EW-1:0], 3);
        chk("R9 two words at wrap", rd_level, 2);
        drive(0, '0, 1);
        chk("R6 hit coarse", rd_data[FW +: CW], CMAX);
        drive(0, '0, 1);
        drive(1, 10'h011, 0);
        chk("R6 still owed", rd_data[EW-1:0], 4);
        drive(0, '0, 1);
        drive(0, '0, 1);

        // Overwrite when full
        for (int i = 0; i < 20; i++) drive(1, FW'(i), 0);
        chk("R7 full after burst", rd_full, 1);
        chk("R8 overrun set", overrun, 1);
        for (int i = 0; i < 4; i++) drive(1, FW'(i + 100), 1);
        chk("R8 level held at depth", rd_level, D);
        for (int i = 0; i < D; i++) drive(0, '0, 1);
        chk("R7 drained", rd_level, 0);
        drive(0, '0, 1);
        chk("R7 pop on empty ignored", rd_level, 0);
        chk("R8 overrun sticky", overrun, 1);

        // Two-word write into an almost full buffer
        for (int i = 0; i < D - 1; i++) drive(1, FW'(i + 200), 0);
        wait_top();
        @(negedge clk);
        drive(1, 10'h123, 0);
        chk("R8 two-word overwrite level", rd_level, D);
        repeat (2) @(negedge clk);

        cmp_on = 0;
        summary();
    end

endmodule